// File: doc/BRIEF.md
# GPIO Edge Interrupt Unit with Debounce

This block turns synchronized GPIO pin levels into per-bank interrupt requests. Each pin has a small configuration word. That word chooses which transitions count as events (rising, falling, both or none). It also controls an optional glitch filter, which accepts a new level only after the level has stayed unchanged for a power-of-two number of millisecond ticks. The block detects level-sensitive triggering nowhere: only transitions of the accepted level can raise an event.

Each event sets a sticky status bit. Software clears that bit by writing a one to it. A per-pin mask has two write ports: one sets mask bits and the other clears them. Each bank of pins drives one interrupt line, which stays high while any status bit in the bank is set and unmasked. Register address decoding and any write protection sit outside the block, which only sees write strobes, a bank select, a pin select and data.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset every status bit is 0, every mask bit is 1, every interrupt line is 0, and every pin configuration is 0 (no edge detection, filter off).
- R2: The configuration word sets the edge type in bits [4:3]. Code 1 detects only rising transitions, code 2 only falling, code 3 both, and code 0 none. A transition of a kind that is not selected leaves status unchanged. Bits [2:0] are ignored.
- R3: A status bit is sticky. It stays set after the pin returns to its earlier level, and only a detected transition can set it.
- R4: A status-clear write clears each status bit of the selected bank whose data bit is 1. It leaves the bits whose data bit is 0, and all bits of other banks, unchanged.
- R5: When a detected transition and a status-clear write hit the same bit in the same cycle, the bit ends up set.
- R6: A mask-set write sets the selected bank's mask bits where data is 1. A mask-clear write clears them. If both writes target the same bit in the same cycle, the bit ends up masked.
- R7: The interrupt line of bank b is high exactly while the bank's status AND NOT mask is nonzero. It depends only on that bank's bits.
- R8: Configuration bit 8 enables the filter, and bits [7:5] hold a code k. With the filter on, a differing input level becomes the accepted level at the 2^k-th tick it has held unchanged. A level that reverts earlier produces no event.
- R9: With the filter off, a pin change present at a clock edge appears in status_o right after that edge.
- R10: A transition that occurs after its status bit was cleared sets the bit again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | NUM_BANKS*PINS_PER_BANK | Synchronized pin levels |
| tick_i | input | 1 | One-cycle pulse every millisecond |
| ctrl_we_i | input | 1 | Configuration write strobe |
| ctrl_pin_i | input | log2(total pins) | Pin that the configuration write targets |
| ctrl_wdata_i | input | 9 | Configuration word |
| wr_bank_i | input | log2(NUM_BANKS) | Bank for status and mask writes |
| stat_clr_i | input | 1 | Status write-one-to-clear strobe |
| mask_set_i | input | 1 | Mask set strobe |
| mask_clr_i | input | 1 | Mask clear strobe |
| wr_data_i | input | PINS_PER_BANK | Per-bit data for status and mask writes |
| status_o | output | NUM_BANKS*PINS_PER_BANK | Sticky event status |
| mask_o | output | NUM_BANKS*PINS_PER_BANK | Current mask |
| irq_o | output | NUM_BANKS | Per-bank interrupt lines |

## Verification
Two functions can fall in the same cycle: a new pin transition setting a status bit, and a write-one-to-clear of that same bit. The same holds for mask-set and mask-clear strobes on the same bit. Directed steps line up a pin change with a clear strobe in one cycle, and with both mask strobes on one bit. Random traffic repeats these collisions many times. The collisions are judged by the requirement that the set side wins, which a cycle-by-cycle reference model enforces.

// File: rtl/gpio_edge_irq_pkg.sv
package gpio_edge_irq_pkg;
  localparam int CTRL_W   = 9;
  localparam int DB_CNT_W = 8;  // holds 2^7 ticks

  typedef struct packed {
    logic       db_en;
    logic [2:0] db_code;
    logic [1:0] edge_sel;  // [0]=rising, [1]=falling
  } pin_cfg_t;

  function automatic pin_cfg_t decode_ctrl(input logic [CTRL_W-1:0] w);
    pin_cfg_t c;
    c.db_en    = w[8];
    c.db_code  = w[7:5];
    c.edge_sel = w[4:3];
    return c;
  endfunction
endpackage

// File: rtl/gpio_pin_chan.sv
module gpio_pin_chan
  import gpio_edge_irq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     pin_i,
  input  logic     tick_i,
  input  logic     cfg_we_i,
  input  pin_cfg_t cfg_i,
  output logic     evt_o
);
  pin_cfg_t              cfg_q;
  logic                  lvl_q, lvl_d;
  logic [DB_CNT_W-1:0]   cnt_q, cnt_d, limit;

  assign limit = DB_CNT_W'(1) << cfg_q.db_code;

  always_comb begin
    lvl_d = lvl_q;
    cnt_d = '0;
    if (!cfg_q.db_en) begin
      lvl_d = pin_i;
    end else if (pin_i != lvl_q) begin
      cnt_d = cnt_q;
      if (tick_i) begin
        // >= keeps a shortened period from stalling a partial count
        if (cnt_q >= limit - DB_CNT_W'(1)) begin
          lvl_d = pin_i;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + DB_CNT_W'(1);
        end
      end
    end
  end

  assign evt_o = (lvl_d & ~lvl_q & cfg_q.edge_sel[0]) |
                 (~lvl_d & lvl_q & cfg_q.edge_sel[1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      cnt_q <= cfg_we_i ? '0 : cnt_d;
      if (cfg_we_i) cfg_q <= cfg_i;
    end
  end

  // R8
  db_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.db_en && !tick_i) |=> $stable(lvl_q));

  // R2
  no_sel_no_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.edge_sel == 2'b00) |-> !evt_o);
endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] evt_i,
  input  logic             stat_clr_i,
  input  logic             mask_set_i,
  input  logic             mask_clr_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] status_o,
  output logic [WIDTH-1:0] mask_o,
  output logic             irq_o
);
  logic [WIDTH-1:0] status_q, mask_q, clr_bits, mset_bits, mclr_bits;

  assign clr_bits  = stat_clr_i ? data_i : '0;
  assign mset_bits = mask_set_i ? data_i : '0;
  assign mclr_bits = mask_clr_i ? data_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      mask_q   <= '1;
    end else begin
      status_q <= (status_q & ~clr_bits) | evt_i;    // set wins
      mask_q   <= (mask_q & ~mclr_bits) | mset_bits; // set wins
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = |(status_q & ~mask_q);

  // R5
  evt_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((status_q & $past(evt_i)) == $past(evt_i)));

  // R4
  w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_clr_i |=> ((status_q & $past(data_i & ~evt_i)) == '0));

  // R3
  no_spurious_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(evt_i)) == '0));

  // R6
  mask_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_set_i |=> ((mask_q & $past(data_i)) == $past(data_i)));

  // R6
  mask_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_clr_i && !mask_set_i) |=> ((mask_q & $past(data_i)) == '0));
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_edge_irq_pkg::*;
#(
  parameter int NUM_BANKS     = 2,
  parameter int PINS_PER_BANK = 8,
  localparam int NUM_PINS     = NUM_BANKS * PINS_PER_BANK,
  localparam int PIN_W        = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
  localparam int BANK_W       = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_PINS-1:0]      pin_i,
  input  logic                     tick_i,
  input  logic                     ctrl_we_i,
  input  logic [PIN_W-1:0]         ctrl_pin_i,
  input  logic [CTRL_W-1:0]        ctrl_wdata_i,
  input  logic [BANK_W-1:0]        wr_bank_i,
  input  logic                     stat_clr_i,
  input  logic                     mask_set_i,
  input  logic                     mask_clr_i,
  input  logic [PINS_PER_BANK-1:0] wr_data_i,
  output logic [NUM_PINS-1:0]      status_o,
  output logic [NUM_PINS-1:0]      mask_o,
  output logic [NUM_BANKS-1:0]     irq_o
);
  pin_cfg_t            cfg_w;
  logic [NUM_PINS-1:0] evt;

  assign cfg_w = decode_ctrl(ctrl_wdata_i);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    gpio_pin_chan u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .pin_i    (pin_i[p]),
      .tick_i   (tick_i),
      .cfg_we_i (ctrl_we_i && (ctrl_pin_i == PIN_W'(p))),
      .cfg_i    (cfg_w),
      .evt_o    (evt[p])
    );
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (wr_bank_i == BANK_W'(b));
    gpio_bank_irq #(.WIDTH(PINS_PER_BANK)) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .evt_i      (evt[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .stat_clr_i (stat_clr_i && hit),
      .mask_set_i (mask_set_i && hit),
      .mask_clr_i (mask_clr_i && hit),
      .data_i     (wr_data_i),
      .status_o   (status_o[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .mask_o     (mask_o[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .irq_o      (irq_o[b])
    );
  end
endmodule

// File: tb/gpio_edge_irq_tb.sv
module gpio_edge_irq_tb;
  localparam int  NB = 2, PPB = 8, NP = NB * PPB;
  localparam time CLK_PERIOD = 10ns;
  localparam int  TDIV = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NP-1:0] pin = '0;
  logic tick = 1'b0, ctrl_we = 1'b0, stat_clr = 1'b0, mset = 1'b0, mclr = 1'b0;
  logic [3:0] ctrl_pin = '0;
  logic [8:0] ctrl_data = '0;
  logic [0:0] bank = '0;
  logic [PPB-1:0] wdata = '0;
  logic [NP-1:0] status, mask;
  logic [NB-1:0] irq;

  int n_chk = 0, n_fail = 0, tcnt = 0;
  string cur_req = "R1";
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_edge_irq #(.NUM_BANKS(NB), .PINS_PER_BANK(PPB)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .tick_i(tick),
    .ctrl_we_i(ctrl_we), .ctrl_pin_i(ctrl_pin), .ctrl_wdata_i(ctrl_data),
    .wr_bank_i(bank), .stat_clr_i(stat_clr), .mask_set_i(mset), .mask_clr_i(mclr),
    .wr_data_i(wdata), .status_o(status), .mask_o(mask), .irq_o(irq));

  // reference model built from the requirements
  logic [8:0]    m_cfg [NP];
  logic [NP-1:0] m_lvl, m_stat, m_mask, m_ev;
  int            m_cnt [NP];

  function automatic logic [NB-1:0] exp_irq(input logic [NP-1:0] s, input logic [NP-1:0] m);
    logic [NB-1:0] r;
    for (int b = 0; b < NB; b++) r[b] = |(s[b*PPB +: PPB] & ~m[b*PPB +: PPB]); // R7
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lvl = '0; m_stat = '0; m_mask = '1; // R1
      for (int p = 0; p < NP; p++) begin m_cfg[p] = '0; m_cnt[p] = 0; end
    end else begin
      for (int p = 0; p < NP; p++) begin
        logic nl;
        nl = m_lvl[p];
        if (!m_cfg[p][8]) begin nl = pin[p]; m_cnt[p] = 0; end        // R9
        else if (pin[p] == m_lvl[p]) m_cnt[p] = 0;
        else if (tick) begin                                          // R8
          if (m_cnt[p] + 1 >= (1 << m_cfg[p][7:5])) begin nl = pin[p]; m_cnt[p] = 0; end
          else m_cnt[p]++;
        end
        m_ev[p] = (nl & ~m_lvl[p] & m_cfg[p][3]) | (~nl & m_lvl[p] & m_cfg[p][4]); // R2
        m_lvl[p] = nl;
        if (ctrl_we && ctrl_pin == 4'(p)) begin m_cfg[p] = ctrl_data; m_cnt[p] = 0; end
      end
      for (int b = 0; b < NB; b++) begin
        if (stat_clr && bank == 1'(b)) m_stat[b*PPB +: PPB] &= ~wdata; // R4
        if (mclr && bank == 1'(b)) m_mask[b*PPB +: PPB] &= ~wdata;
        if (mset && bank == 1'(b)) m_mask[b*PPB +: PPB] |= wdata;     // R6
      end
      m_stat |= m_ev; // R5 R10
    end
  end

  task automatic cmp(input string what, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic expect_bit(input string req, input int p, input logic e);
    n_chk++;
    if (status[p] !== e) begin
      n_fail++;
      $display("FAIL %s status[%0d] act=%b exp=%b", req, p, status[p], e);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    cmp("status", status, m_stat);
    cmp("mask", mask, m_mask);
    cmp("irq", NP'(irq), NP'(exp_irq(m_stat, m_mask)));
    ctrl_we = 0; stat_clr = 0; mset = 0; mclr = 0;
    tcnt++;
    tick = (tcnt % TDIV) == 0;
  endtask

  task automatic wr_ctrl(input int p, input logic [8:0] d);
    ctrl_we = 1; ctrl_pin = 4'(p); ctrl_data = d; step();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    #(CLK_PERIOD * 3); rst_n = 1;
    cur_req = "R1"; step();
    n_chk++;
    if (status !== '0 || mask !== '1 || irq !== '0) begin
      n_fail++; $display("FAIL R1 reset act=%h/%h/%h exp=0/ffff/0", status, mask, irq);
    end
    bank = 0; wdata = '1; mclr = 1; step();
    bank = 1; wdata = '1; mclr = 1; step();

    // R2 R9: rising only on pin 0
    cur_req = "R2";
    wr_ctrl(0, 9'h008);
    pin[0] = 1; step(); expect_bit("R9", 0, 1);
    bank = 0; wdata = 8'h01; stat_clr = 1; step(); expect_bit("R4", 0, 0);
    pin[0] = 0; step(); expect_bit("R2", 0, 0);
    wr_ctrl(2, 9'h017);  // falling, low bits ignored
    pin[2] = 1; step(); expect_bit("R2", 2, 0);
    pin[2] = 0; step(); expect_bit("R2", 2, 1);
    // R3 R10 both edges on pin 3
    cur_req = "R10";
    wr_ctrl(3, 9'h018);
    pin[3] = 1; step(); run(3); expect_bit("R3", 3, 1);
    bank = 0; wdata = 8'h08; stat_clr = 1; step();
    pin[3] = 0; step(); expect_bit("R10", 3, 1);
    wr_ctrl(4, 9'h000);
    pin[4] = 1; step(); pin[4] = 0; step(); expect_bit("R2", 4, 0);

    // R5: edge and clear collide on bit 0; bit 2 clears
    cur_req = "R5";
    pin[0] = 1; bank = 0; wdata = 8'h05; stat_clr = 1; step();
    expect_bit("R5", 0, 1); expect_bit("R4", 2, 0);

    // R6 R7
    cur_req = "R7";
    bank = 0; wdata = 8'hff; mset = 1; step();
    n_chk++; if (irq[0] !== 1'b0) begin n_fail++; $display("FAIL R7 irq0 act=%b exp=0", irq[0]); end
    cur_req = "R6";
    bank = 0; wdata = 8'h01; mset = 1; mclr = 1; step();
    n_chk++; if (mask[0] !== 1'b1) begin n_fail++; $display("FAIL R6 mask0 act=%b exp=1", mask[0]); end
    bank = 0; wdata = 8'h01; mclr = 1; step();
    n_chk++; if (irq !== 2'b01) begin n_fail++; $display("FAIL R7 irq act=%b exp=01", irq); end

    // R8: filter on pin 9, period 4 ticks, both edges
    cur_req = "R8";
    wr_ctrl(9, 9'h158);
    pin[9] = 1; run(12); pin[9] = 0; run(8); expect_bit("R8", 9, 0);
    pin[9] = 1; run(24); expect_bit("R8", 9, 1);
    wr_ctrl(9, 9'h1f8);  // period 128 ticks
    bank = 1; wdata = 8'h02; stat_clr = 1; step();
    pin[9] = 0; run(TDIV * 127 - 4); expect_bit("R8", 9, 0);
    run(TDIV * 2); expect_bit("R8", 9, 1);

    // random mix
    cur_req = "R4";
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 7) == 0) pin[$urandom_range(0, NP-1)] ^= 1'b1;
      if ($urandom_range(0, 19) == 0) begin
        ctrl_we = 1; ctrl_pin = 4'($urandom_range(0, NP-1));
        ctrl_data = 9'($urandom) & (($urandom_range(0, 3) == 0) ? 9'h1ff : 9'h0ff);
      end
      bank = 1'($urandom); wdata = 8'($urandom);
      stat_clr = ($urandom_range(0, 5) == 0);
      mset = ($urandom_range(0, 9) == 0);
      mclr = ($urandom_range(0, 7) == 0);
      step();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule